// File: doc/BRIEF.md
# Double to Extended-Precision Converter

This block moves floating-point values between the IEEE-754 binary64 format and the 80-bit extended format. The extended format has a 15-bit exponent biased by 16383 and a 64-bit significand whose top bit is an explicit integer bit. It has two independent paths. The widening path turns a double into an extended value. It presents that value as three words in the order a 10-byte store writes them: significand bits 31:0, then significand bits 63:32, then a 16-bit word that holds the sign and exponent.

The narrowing path takes those three words back and produces a double. It normalizes the significand, which may or may not carry its integer bit. Any bits that do not fit are dropped, so the result is always truncated. Results that are too large become infinity. Results that are too small become a subnormal double or a signed zero.

Each path accepts one value per cycle through a valid/ready handshake and holds its result in a single register stage. Rounding-mode control and exception flags are not part of the block.

Top module: `fpx_convert`

## Requirements
- R1: For a double with biased exponent e in 1..2046, the widened sign/exponent word has the sign in bit 15 and e + 15360 in bits 14:0. The significand has bit 63 set and the 52 fraction bits in bits 62:11, with bits 10:0 zero.
- R2: For a double with exponent 0 (zero or subnormal), the widened exponent is 0 and the significand is the fraction shifted left by 11, with bit 63 clear. The sign is still kept in bit 15.
- R3: For a double with exponent 0x7FF (infinity or NaN), the widened exponent is 0x7FFF and the significand is bit 63 set with the fraction in bits 62:11.
- R4: The widened significand appears with bits 31:0 on the low word port and bits 63:32 on the high word port. The sign/exponent word is on its own 16-bit port.
- R5: On the narrowing path, for a nonzero significand s with leading-zero count z and extended exponent E below 0x7FFF, the double's biased exponent is b = E − 15360 − z. When b lies in 1..2046, the fraction is bits 62:11 of s shifted left by z, truncated.
- R6: On the narrowing path, if b ≥ 2047 the result is infinity (exponent 0x7FF, fraction 0) with the input sign.
- R7: On the narrowing path, if b ≤ 0 the result has exponent 0. Its fraction is the 53-bit normalized significand (integer bit included) shifted right by 1 − b, truncated, which gives zero when the shift exceeds 52. A zero significand gives a zero result. The sign is kept in every case.
- R8: On the narrowing path, when E = 0x7FFF the result exponent is 0x7FF. If s bits 62:0 are zero the result is infinity. Otherwise it is a NaN with fraction bit 51 set and s bits 61:11 in fraction bits 50:0. This check takes priority over the zero-significand case.
- R9: On each path, an input is accepted when valid and ready are both high, and its result is presented with output valid high on the following cycle. While output valid is high and output ready is low, the output data holds steady and input ready is low. Input ready is high whenever the output stage is empty.
- R10: Asserting the active-low reset clears both output valid signals at once. After reset both input ready signals are high.
- R11: Traffic on one path does not change the valid signal or the data held on the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wid_in_valid | input | 1 | Double to be widened is present |
| wid_in_ready | output | 1 | Widening path can take an input |
| wid_in_dbl | input | 64 | Binary64 input |
| wid_out_valid | output | 1 | Widened result is present |
| wid_out_ready | input | 1 | Consumer takes the widened result |
| wid_out_lo | output | 32 | Significand bits 31:0 |
| wid_out_hi | output | 32 | Significand bits 63:32 |
| wid_out_se | output | 16 | Sign (bit 15) and exponent (bits 14:0) |
| nar_in_valid | input | 1 | Extended value to be narrowed is present |
| nar_in_ready | output | 1 | Narrowing path can take an input |
| nar_in_lo | input | 32 | Significand bits 31:0 |
| nar_in_hi | input | 32 | Significand bits 63:32 |
| nar_in_se | input | 16 | Sign and exponent word |
| nar_out_valid | output | 1 | Narrowed result is present |
| nar_out_ready | input | 1 | Consumer takes the narrowed result |
| nar_out_dbl | output | 64 | Binary64 result |

## Verification
The hardest corner to reach from the ports is the edge of the narrowing path's underflow region. There the biased exponent ends up just above or below the point where a single remaining bit shifts out. It only shows up when the extended exponent is chosen to land the result at the smallest subnormal, or one step below it. The stimulus picks exponents 0x3C00, 0x3BCD and 0x3BCC with a lone integer bit to straddle that edge. It also feeds a significand without its integer bit, which exercises the normalizing shift. Backpressure is reached by holding output ready low while a second input waits. Independence of the two paths is reached by parking a narrowed result during all widening traffic.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int DBL_W      = 64;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int EXT_EXP_W  = 15;
    localparam int EXT_SIG_W  = 64;
    localparam int WORD_W     = 32;
    localparam int SE_W       = EXT_EXP_W + 1;
    localparam int EXT_W      = EXT_SIG_W + SE_W;
    localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
    localparam int EXT_BIAS   = (1 << (EXT_EXP_W - 1)) - 1;
    localparam int REBIAS     = EXT_BIAS - DBL_BIAS;
    localparam int SIG_PAD    = EXT_SIG_W - 1 - DBL_FRAC_W;
    localparam int DBL_EMAX   = (1 << DBL_EXP_W) - 1;
    localparam int MANT_W     = DBL_FRAC_W + 1;
    localparam int LZ_W       = $clog2(EXT_SIG_W + 1);

    typedef struct packed {
        logic                  sign;
        logic [DBL_EXP_W-1:0]  exp;
        logic [DBL_FRAC_W-1:0] frac;
    } dbl_t;

    typedef struct packed {
        logic                 sign;
        logic [EXT_EXP_W-1:0] exp;
        logic [EXT_SIG_W-1:0] sig;
    } ext_t;
endpackage

// File: rtl/fpx_lzc.sv
module fpx_lzc #(
    parameter int WIDTH = 64,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CNT_W-1:0] cnt
);
    // above_zero[i]: every bit above position i is zero
    logic [WIDTH-1:0] above_zero;
    logic [WIDTH-1:0] first_one;

    assign above_zero[WIDTH-1] = 1'b1;
    genvar g;
    generate
        for (g = WIDTH - 2; g >= 0; g--) begin : g_scan
            assign above_zero[g] = above_zero[g+1] & ~vec[g+1];
        end
        for (g = 0; g < WIDTH; g++) begin : g_first
            assign first_one[g] = above_zero[g] & vec[g];
        end
    endgenerate

    always_comb begin
        cnt = CNT_W'(WIDTH);
        for (int i = 0; i < WIDTH; i++) begin
            if (first_one[i]) cnt = CNT_W'(WIDTH - 1 - i);
        end
    end
endmodule

// File: rtl/fpx_widen.sv
module fpx_widen
    import fpx_pkg::*;
(
    input  dbl_t din,
    output ext_t dout
);
    always_comb begin
        dout.sign = din.sign;
        if (din.exp == '0) begin
            dout.exp = '0;
            dout.sig = {1'b0, din.frac, {SIG_PAD{1'b0}}};
        end else if (din.exp == DBL_EXP_W'(DBL_EMAX)) begin
            dout.exp = '1;
            dout.sig = {1'b1, din.frac, {SIG_PAD{1'b0}}};
        end else begin
            dout.exp = EXT_EXP_W'(din.exp) + EXT_EXP_W'(REBIAS);
            dout.sig = {1'b1, din.frac, {SIG_PAD{1'b0}}};
        end
    end
endmodule

// File: rtl/fpx_narrow.sv
module fpx_narrow
    import fpx_pkg::*;
(
    input  ext_t din,
    output dbl_t dout
);
    logic [LZ_W-1:0]      lz;
    logic [EXT_SIG_W-1:0] norm;
    logic [MANT_W-1:0]    mant;
    logic [MANT_W-1:0]    mant_sh;
    int                   bexp;
    int                   rsh;

    fpx_lzc #(.WIDTH(EXT_SIG_W)) u_lzc (
        .vec (din.sig),
        .cnt (lz)
    );

    always_comb begin
        norm    = din.sig << lz;
        mant    = {1'b1, norm[EXT_SIG_W-2 -: DBL_FRAC_W]};
        bexp    = int'(din.exp) - REBIAS - int'(lz);
        rsh     = 1 - bexp;
        mant_sh = (rsh >= 0 && rsh <= MANT_W) ? (mant >> rsh[6:0]) : '0;

        dout.sign = din.sign;
        dout.exp  = '0;
        dout.frac = '0;
        if (din.exp == '1) begin
            dout.exp = '1;
            if (din.sig[EXT_SIG_W-2:0] != '0)
                dout.frac = {1'b1, din.sig[EXT_SIG_W-3 -: DBL_FRAC_W-1]};
        end else if (din.sig == '0) begin
            dout.exp  = '0;
        end else if (bexp >= DBL_EMAX) begin
            dout.exp  = '1;
        end else if (bexp >= 1) begin
            dout.exp  = bexp[DBL_EXP_W-1:0];
            dout.frac = norm[EXT_SIG_W-2 -: DBL_FRAC_W];
        end else begin
            dout.frac = mant_sh[DBL_FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/fpx_stage.sv
module fpx_stage #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);
    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] dat;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.vld || out_ready;
        if (in_valid && in_ready) begin
            st_d.vld = 1'b1;
            st_d.dat = in_data;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;
endmodule

// File: rtl/fpx_convert.sv
module fpx_convert
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wid_in_valid,
    output logic              wid_in_ready,
    input  logic [DBL_W-1:0]  wid_in_dbl,
    output logic              wid_out_valid,
    input  logic              wid_out_ready,
    output logic [WORD_W-1:0] wid_out_lo,
    output logic [WORD_W-1:0] wid_out_hi,
    output logic [SE_W-1:0]   wid_out_se,
    input  logic              nar_in_valid,
    output logic              nar_in_ready,
    input  logic [WORD_W-1:0] nar_in_lo,
    input  logic [WORD_W-1:0] nar_in_hi,
    input  logic [SE_W-1:0]   nar_in_se,
    output logic              nar_out_valid,
    input  logic              nar_out_ready,
    output logic [DBL_W-1:0]  nar_out_dbl
);
    ext_t wid_ext;
    ext_t nar_ext;
    dbl_t nar_dbl;
    logic [EXT_W-1:0] wid_words_d, wid_words_q;

    // widening path: compute, then pack into store order {se, hi, lo}
    fpx_widen u_widen (
        .din  (dbl_t'(wid_in_dbl)),
        .dout (wid_ext)
    );

    assign wid_words_d = {wid_ext.sign, wid_ext.exp,
                          wid_ext.sig[EXT_SIG_W-1 -: WORD_W],
                          wid_ext.sig[WORD_W-1:0]};

    fpx_stage #(.WIDTH(EXT_W)) u_wid_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (wid_in_valid),
        .in_ready  (wid_in_ready),
        .in_data   (wid_words_d),
        .out_valid (wid_out_valid),
        .out_ready (wid_out_ready),
        .out_data  (wid_words_q)
    );

    assign wid_out_se = wid_words_q[EXT_W-1 -: SE_W];
    assign wid_out_hi = wid_words_q[2*WORD_W-1 -: WORD_W];
    assign wid_out_lo = wid_words_q[WORD_W-1:0];

    // narrowing path
    assign nar_ext.sign = nar_in_se[SE_W-1];
    assign nar_ext.exp  = nar_in_se[EXT_EXP_W-1:0];
    assign nar_ext.sig  = {nar_in_hi, nar_in_lo};

    fpx_narrow u_narrow (
        .din  (nar_ext),
        .dout (nar_dbl)
    );

    fpx_stage #(.WIDTH(DBL_W)) u_nar_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (nar_in_valid),
        .in_ready  (nar_in_ready),
        .in_data   (DBL_W'(nar_dbl)),
        .out_valid (nar_out_valid),
        .out_ready (nar_out_ready),
        .out_data  (nar_out_dbl)
    );
endmodule

// File: rtl/fpx_convert_chk.sv
module fpx_convert_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wid_in_valid,
    input logic        wid_in_ready,
    input logic        wid_out_valid,
    input logic        wid_out_ready,
    input logic [31:0] wid_out_lo,
    input logic [31:0] wid_out_hi,
    input logic [15:0] wid_out_se,
    input logic        nar_in_valid,
    input logic        nar_in_ready,
    input logic        nar_out_valid,
    input logic        nar_out_ready,
    input logic [63:0] nar_out_dbl
);
    // R9
    wid_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wid_in_valid && wid_in_ready |=> wid_out_valid);

    // R9
    nar_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nar_in_valid && nar_in_ready |=> nar_out_valid);

    // R9
    wid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wid_out_valid && !wid_out_ready |=>
            wid_out_valid && $stable({wid_out_se, wid_out_hi, wid_out_lo}));

    // R9
    nar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nar_out_valid && !nar_out_ready |=> nar_out_valid && $stable(nar_out_dbl));

    // R9
    wid_empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wid_out_valid |-> wid_in_ready);

    // R1
    wid_int_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wid_out_valid && wid_out_se[14:0] != 15'd0 |-> wid_out_hi[31]);

    // R2
    wid_no_int_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wid_out_valid && wid_out_se[14:0] == 15'd0 |-> !wid_out_hi[31]);
endmodule

bind fpx_convert fpx_convert_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wid_in_valid  (wid_in_valid),
    .wid_in_ready  (wid_in_ready),
    .wid_out_valid (wid_out_valid),
    .wid_out_ready (wid_out_ready),
    .wid_out_lo    (wid_out_lo),
    .wid_out_hi    (wid_out_hi),
    .wid_out_se    (wid_out_se),
    .nar_in_valid  (nar_in_valid),
    .nar_in_ready  (nar_in_ready),
    .nar_out_valid (nar_out_valid),
    .nar_out_ready (nar_out_ready),
    .nar_out_dbl   (nar_out_dbl)
);

// File: tb/fpx_convert_tb.sv
module fpx_convert_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 12;
    localparam int NN = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wid_in_valid = 1'b0;
    logic        wid_in_ready;
    logic [63:0] wid_in_dbl = '0;
    logic        wid_out_valid;
    logic        wid_out_ready = 1'b1;
    logic [31:0] wid_out_lo, wid_out_hi;
    logic [15:0] wid_out_se;
    logic        nar_in_valid = 1'b0;
    logic        nar_in_ready;
    logic [31:0] nar_in_lo = '0, nar_in_hi = '0;
    logic [15:0] nar_in_se = '0;
    logic        nar_out_valid;
    logic        nar_out_ready = 1'b1;
    logic [63:0] nar_out_dbl;

    int applied = 0;
    int bad = 0;

    // widening vectors: input double, expected {se, hi, lo}
    localparam logic [63:0] W_IN [NW] = '{
        64'h3FF0_0000_0000_0000,   // R1  1.0
        64'hC004_0000_0000_0000,   // R1  -2.5
        64'h3FF0_0000_0000_0001,   // R4  low word carries the ulp
        64'h0010_0000_0000_0000,   // R1  smallest normal
        64'h7FEF_FFFF_FFFF_FFFF,   // R1  largest normal
        64'h0000_0000_0000_0000,   // R2  +0
        64'h8000_0000_0000_0000,   // R2  -0
        64'h0000_0000_0000_0001,   // R2  smallest subnormal
        64'h000F_FFFF_FFFF_FFFF,   // R2  largest subnormal
        64'h7FF0_0000_0000_0000,   // R3  +inf
        64'h7FF8_0000_0000_0000,   // R3  quiet NaN
        64'hFFF0_0000_0000_0001    // R3  signalling NaN, negative
    };
    localparam logic [79:0] W_EXP [NW] = '{
        80'h3FFF_8000_0000_0000_0000,
        80'hC000_A000_0000_0000_0000,
        80'h3FFF_8000_0000_0000_0800,
        80'h3C01_8000_0000_0000_0000,
        80'h43FE_FFFF_FFFF_FFFF_F800,
        80'h0000_0000_0000_0000_0000,
        80'h8000_0000_0000_0000_0000,
        80'h0000_0000_0000_0000_0800,
        80'h0000_7FFF_FFFF_FFFF_F800,
        80'h7FFF_8000_0000_0000_0000,
        80'h7FFF_C000_0000_0000_0000,
        80'hFFFF_8000_0000_0000_0800
    };
    localparam logic [23:0] W_REQ [NW] = '{
        "R1 ", "R1 ", "R4 ", "R1 ", "R1 ", "R2 ",
        "R2 ", "R2 ", "R2 ", "R3 ", "R3 ", "R3 "
    };

    // narrowing vectors: input {se, hi, lo}, expected double
    localparam logic [79:0] N_IN [NN] = '{
        80'h3FFF_8000_0000_0000_0000,   // R5
        80'hC000_A000_0000_0000_0000,   // R5
        80'h3FFF_8000_0000_0000_0FFF,   // R5 truncation
        80'h4000_4000_0000_0000_0000,   // R5 missing integer bit
        80'h43FE_FFFF_FFFF_FFFF_FFFF,   // R5 largest normal
        80'h43FF_8000_0000_0000_0000,   // R6
        80'hC3FF_8000_0000_0000_0000,   // R6 negative
        80'h3C00_8000_0000_0000_0000,   // R7 subnormal 2^-1023
        80'h3C00_C000_0000_0000_0000,   // R7 subnormal two bits
        80'h3BCD_8000_0000_0000_0000,   // R7 smallest subnormal
        80'hBBCC_8000_0000_0000_0000,   // R7 one step below, negative
        80'h8005_0000_0000_0000_0000,   // R7 zero significand
        80'h0000_0000_0000_0000_0800,   // R7 widened subnormal
        80'h7FFF_8000_0000_0000_0000,   // R8 +inf
        80'hFFFF_8000_0000_0000_0000,   // R8 -inf
        80'h7FFF_C000_0000_0000_0000,   // R8 NaN
        80'h7FFF_8000_0000_0000_0001,   // R8 NaN payload below cut
        80'h7FFF_C000_0000_0000_0800    // R8 NaN payload kept
    };
    localparam logic [63:0] N_EXP [NN] = '{
        64'h3FF0_0000_0000_0000,
        64'hC004_0000_0000_0000,
        64'h3FF0_0000_0000_0001,
        64'h3FF0_0000_0000_0000,
        64'h7FEF_FFFF_FFFF_FFFF,
        64'h7FF0_0000_0000_0000,
        64'hFFF0_0000_0000_0000,
        64'h0008_0000_0000_0000,
        64'h000C_0000_0000_0000,
        64'h0000_0000_0000_0001,
        64'h8000_0000_0000_0000,
        64'h8000_0000_0000_0000,
        64'h0000_0000_0000_0000,
        64'h7FF0_0000_0000_0000,
        64'hFFF0_0000_0000_0000,
        64'h7FF8_0000_0000_0000,
        64'h7FF8_0000_0000_0000,
        64'h7FF8_0000_0000_0001
    };
    localparam logic [23:0] N_REQ [NN] = '{
        "R5 ", "R5 ", "R5 ", "R5 ", "R5 ", "R6 ", "R6 ", "R7 ", "R7 ",
        "R7 ", "R7 ", "R7 ", "R7 ", "R8 ", "R8 ", "R8 ", "R8 ", "R8 "
    };

    fpx_convert u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wid_in_valid  (wid_in_valid),
        .wid_in_ready  (wid_in_ready),
        .wid_in_dbl    (wid_in_dbl),
        .wid_out_valid (wid_out_valid),
        .wid_out_ready (wid_out_ready),
        .wid_out_lo    (wid_out_lo),
        .wid_out_hi    (wid_out_hi),
        .wid_out_se    (wid_out_se),
        .nar_in_valid  (nar_in_valid),
        .nar_in_ready  (nar_in_ready),
        .nar_in_lo     (nar_in_lo),
        .nar_in_hi     (nar_in_hi),
        .nar_in_se     (nar_in_se),
        .nar_out_valid (nar_out_valid),
        .nar_out_ready (nar_out_ready),
        .nar_out_dbl   (nar_out_dbl)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input logic [23:0] req, input logic [79:0] act, input logic [79:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic widen_one(input logic [63:0] d);
        @(negedge clk);
        wid_in_valid = 1'b1;
        wid_in_dbl   = d;
        @(posedge clk);
        @(negedge clk);
        wid_in_valid = 1'b0;
    endtask

    task automatic narrow_one(input logic [79:0] x);
        @(negedge clk);
        nar_in_valid = 1'b1;
        {nar_in_se, nar_in_hi, nar_in_lo} = x;
        @(posedge clk);
        @(negedge clk);
        nar_in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", 80'({wid_out_valid, nar_out_valid, wid_in_ready, nar_in_ready}), 80'b0011);

        // park a narrowed result, then run widening traffic (R11)
        nar_out_ready = 1'b0;
        narrow_one(80'h3FFF_8000_0000_0000_0000);
        for (int i = 0; i < NW; i++) begin
            widen_one(W_IN[i]);
            check(W_REQ[i], {wid_out_valid, wid_out_se, wid_out_hi, wid_out_lo}[79:0],
                  W_EXP[i]);
            check("R9 ", 80'(wid_out_valid), 80'd1);
        end
        check("R11", {15'd0, nar_out_valid, nar_out_dbl}, {15'd0, 1'b1, 64'h3FF0_0000_0000_0000});
        @(negedge clk);
        nar_out_ready = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NN; i++) begin
            narrow_one(N_IN[i]);
            check(N_REQ[i], {15'd0, nar_out_valid, nar_out_dbl}, {15'd0, 1'b1, N_EXP[i]});
        end

        // R9 backpressure on the widening path
        wid_out_ready = 1'b0;
        widen_one(64'h3FF0_0000_0000_0000);
        @(negedge clk);
        wid_in_valid = 1'b1;
        wid_in_dbl   = 64'hC004_0000_0000_0000;
        #1;
        check("R9 ", 80'({wid_out_valid, wid_in_ready}), 80'b10);
        @(posedge clk);
        @(negedge clk);
        check("R9 ", {wid_out_se, wid_out_hi, wid_out_lo}, 80'h3FFF_8000_0000_0000_0000);
        check("R9 ", 80'(wid_in_ready), 80'd0);
        wid_out_ready = 1'b1;
        #1;
        check("R9 ", 80'(wid_in_ready), 80'd1);
        @(posedge clk);
        @(negedge clk);
        wid_in_valid = 1'b0;
        check("R9 ", {wid_out_se, wid_out_hi, wid_out_lo}, 80'hC000_A000_0000_0000_0000);
        @(posedge clk);
        @(negedge clk);
        check("R9 ", 80'(wid_out_valid), 80'd0);

        // R10 reset while results are held
        wid_out_ready = 1'b0;
        nar_out_ready = 1'b0;
        widen_one(64'h3FF0_0000_0000_0000);
        narrow_one(80'h3FFF_8000_0000_0000_0000);
        check("R10", 80'({wid_out_valid, nar_out_valid}), 80'b11);
        rst_n = 1'b0;
        #1;
        check("R10", 80'({wid_out_valid, nar_out_valid}), 80'b00);
        @(negedge clk);
        rst_n = 1'b1;
        wid_out_ready = 1'b1;
        nar_out_ready = 1'b1;
        @(negedge clk);
        check("R10", 80'({wid_in_ready, nar_in_ready}), 80'b11);

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule